// File: doc/BRIEF.md
# Chip-select framed serial converter port with power control

This block is the digital face of a serial sampling converter. A host lowers an active-low select line to start a frame and then supplies sixteen falling edges on a serial clock. The block answers on a data line that it drives only while a frame is open: four zero bits, then a 12-bit sample word from the converter stub, most significant bit first. Both host pins are brought into the system clock domain through two-flop synchronisers, and all edge detection happens there. The serial clock must be at least four times slower than the system clock.

The block also keeps the converter's power state. The number of serial clock falls counted when the select line rises decides what happens. Too few falls is a glitch and is ignored. A middling count abandons the frame and powers down. A late count abandons the frame but stays powered. While powered down, the next frame is a dummy wake-up frame. Its data is marked invalid, and it restores power only if it lasts past the tenth fall. Power returns after a settling delay counted in system clocks. A frame started before that delay ends is also marked invalid. After a completed frame, a quiet interval must pass before a new frame is accepted.

Top module: `adc_frame_ctrl`

## Requirements
- R1: After reset, sdata_oe_o and sdata_o are 0, powered_o is 1 and valid_o is 0.
- R2: A falling edge on cs_n_i opens a frame: sdata_oe_o rises on the third rising clk edge that samples the new pin level. Each pin change acts with that same latency.
- R3: The frame word is 4 zero bits followed by sample_i as captured when the frame opens, MSB first. Bit 0 of the word is on sdata_o as soon as the frame opens. Bit k (1 to 15) appears after the k-th counted serial clock fall. sdata_o is 0 whenever sdata_oe_o is 0.
- R4: On the 16th counted fall the frame completes: sdata_oe_o drops and the power state is unchanged. A later rise of cs_n_i has no effect.
- R5: If cs_n_i rises with 0 or 1 falls counted, the frame is abandoned (sdata_oe_o drops) and powered_o keeps its value.
- R6: If cs_n_i rises with 2 to 9 falls counted, in a frame that is not a wake-up frame, the frame is abandoned and powered_o goes to 0.
- R7: If cs_n_i rises with 10 to 15 falls counted, the frame is abandoned and powered_o keeps its value.
- R8: A frame opened while powered down is a wake-up frame. If cs_n_i rises in it before the 10th fall is counted, the block returns to powered down and powered_o stays 0.
- R9: A wake-up frame that reaches its 10th fall restores power. powered_o rises PWRUP_CYC+1 clk cycles after the wake-up frame opens, or one cycle after the tenth fall is counted if that comes later. valid_o is 0 for the wake-up frame.
- R10: When a frame opens, valid_o is set to 1 if powered_o was 1 at that moment and to 0 otherwise. It holds that value until the next frame opens.
- R11: A cs_n_i fall that arrives while the quiet counter (QUIET_CYC cycles, loaded when a frame completes) is nonzero is ignored. No frame opens and sdata_oe_o stays 0.
- R12: A serial clock fall seen in the same cycle as a cs_n_i rise is counted first, and the rise is judged on the updated count. A serial clock fall seen in the same cycle as the frame-opening cs_n_i fall is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Host select, active low, asynchronous |
| sclk_i | input | 1 | Host serial clock, asynchronous |
| sample_i | input | 12 | Sample word from the converter stub |
| sdata_o | output | 1 | Serial data, 0 when not enabled |
| sdata_oe_o | output | 1 | Output enable for the serial data pad |
| powered_o | output | 1 | 1 while the converter is fully powered |
| valid_o | output | 1 | 1 if the current or last frame carries valid data |

## Verification
The interesting collisions are a select rise and a serial clock fall that land in the same synchronised cycle. The outcome then depends on whether the fall is counted before the rise is judged. The bench drives both pins at the same instant, once on the 2nd fall and once on the 10th fall. It expects power-down in the first case and a plain abort in the second. It also opens a frame together with a serial clock fall and expects exactly sixteen further falls to complete the frame. A cycle-by-cycle behavioural model compares all four outputs on every clock, including the wake-up timer expiring while a frame is still open.

// File: rtl/adc_fsm_pkg.sv
package adc_fsm_pkg;

    typedef enum logic [1:0] {
        PW_UP   = 2'd0,
        PW_DOWN = 2'd1,
        PW_WAKE = 2'd2
    } pwr_state_e;

endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
    parameter int              N       = 2,
    parameter int              STAGES  = 2,
    parameter logic [N-1:0]    RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] fall_o,
    output logic [N-1:0] rise_o
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [STAGES:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-1:0], pin_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {(STAGES+1){RST_VAL[g]}};
            else        chain_q <= chain_d;
        end

        assign fall_o[g] =  chain_q[STAGES] & ~chain_q[STAGES-1];
        assign rise_o[g] = ~chain_q[STAGES] &  chain_q[STAGES-1];
    end

endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift #(
    parameter int DATA_W    = 12,
    parameter int LEAD_W    = 4,
    parameter int QUIET_CYC = 16,
    localparam int FRAME_W  = DATA_W + LEAD_W,
    localparam int CNT_W    = $clog2(FRAME_W + 1),
    localparam int QW       = $clog2(QUIET_CYC + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall_i,
    input  logic              cs_rise_i,
    input  logic              sclk_fall_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              start_o,
    output logic              step_o,
    output logic              abort_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              sdata_o,
    output logic              oe_o
);

    typedef struct packed {
        logic               active;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] word;
        logic [QW-1:0]      quiet;
    } frame_t;

    frame_t cur_q, nx_d;
    logic   done;

    always_comb begin
        nx_d    = cur_q;
        start_o = 1'b0;
        step_o  = 1'b0;
        abort_o = 1'b0;
        done    = 1'b0;
        if (cs_fall_i && !cur_q.active && cur_q.quiet == '0) begin
            start_o     = 1'b1;
            nx_d.active = 1'b1;
            nx_d.cnt    = '0;
            nx_d.word   = {{LEAD_W{1'b0}}, sample_i};
        end else if (cur_q.active) begin
            // count the clock edge first, then judge a select rise
            if (sclk_fall_i) begin
                step_o    = 1'b1;
                nx_d.cnt  = cur_q.cnt + 1'b1;
                nx_d.word = {cur_q.word[FRAME_W-2:0], 1'b0};
                if (nx_d.cnt == CNT_W'(FRAME_W)) begin
                    nx_d.active = 1'b0;
                    done        = 1'b1;
                end
            end
            if (cs_rise_i && nx_d.active) begin
                nx_d.active = 1'b0;
                abort_o     = 1'b1;
            end
        end
        if (done)                  nx_d.quiet = QW'(QUIET_CYC);
        else if (cur_q.quiet != 0) nx_d.quiet = cur_q.quiet - 1'b1;
        cnt_o = nx_d.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nx_d;
    end

    assign oe_o    = cur_q.active;
    assign sdata_o = cur_q.active & cur_q.word[FRAME_W-1];

    a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.active |-> (cur_q.cnt < CNT_W'(FRAME_W)));

    a_r2_open_needs_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.active) |-> $past(cs_fall_i));

    a_r11_quiet_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.quiet != 0 && !(cur_q.active && sclk_fall_i)) |=> (cur_q.quiet == $past(cur_q.quiet) - 1'b1));

endmodule

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl
    import adc_fsm_pkg::*;
#(
    parameter int FRAME_W   = 16,
    parameter int PD_LO     = 2,
    parameter int PD_HI     = 10,
    parameter int PWRUP_CYC = 200,
    localparam int CNT_W    = $clog2(FRAME_W + 1),
    localparam int TMR_W    = $clog2(PWRUP_CYC + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             step_i,
    input  logic             abort_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             powered_o,
    output logic             valid_o
);

    typedef struct packed {
        pwr_state_e       state;
        logic [TMR_W-1:0] tmr;
        logic             commit;
        logic             dummy;
        logic             valid;
    } pwr_t;

    pwr_t cur_q, nx_d;

    always_comb begin
        nx_d = cur_q;
        if (cur_q.state == PW_WAKE && cur_q.tmr != TMR_W'(PWRUP_CYC))
            nx_d.tmr = cur_q.tmr + 1'b1;
        if (cur_q.state == PW_WAKE && cur_q.commit && cur_q.tmr == TMR_W'(PWRUP_CYC))
            nx_d.state = PW_UP;
        if (start_i) begin
            if (cur_q.state == PW_DOWN) begin
                nx_d.state  = PW_WAKE;
                nx_d.tmr    = '0;
                nx_d.commit = 1'b0;
                nx_d.dummy  = 1'b1;
                nx_d.valid  = 1'b0;
            end else begin
                nx_d.dummy = 1'b0;
                nx_d.valid = (cur_q.state == PW_UP);
            end
        end
        if (step_i && cur_q.dummy && cnt_i == CNT_W'(PD_HI))
            nx_d.commit = 1'b1;
        if (abort_i) begin
            if (cur_q.dummy) begin
                if (cnt_i < CNT_W'(PD_HI)) begin
                    nx_d.state  = PW_DOWN;
                    nx_d.commit = 1'b0;
                    nx_d.dummy  = 1'b0;
                end
            end else if (cnt_i >= CNT_W'(PD_LO) && cnt_i < CNT_W'(PD_HI)) begin
                nx_d.state = PW_DOWN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.state <= PW_UP;
        end else begin
            cur_q <= nx_d;
        end
    end

    assign powered_o = (cur_q.state == PW_UP);
    assign valid_o   = cur_q.valid;

    a_r9_up_only_from_wake: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.state == PW_UP) |-> ($past(cur_q.state) == PW_WAKE));

    a_r10_valid_set_at_open: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.valid) |-> $past(start_i));

    a_r6_down_needs_abort: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.state == PW_DOWN) |-> $past(abort_i));

    a_r8_wake_from_down: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.state == PW_WAKE) |-> ($past(cur_q.state) == PW_DOWN && $past(start_i)));

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl #(
    parameter int DATA_W    = 12,
    parameter int LEAD_W    = 4,
    parameter int SYNC_STG  = 2,
    parameter int PD_LO     = 2,
    parameter int PD_HI     = 10,
    parameter int PWRUP_CYC = 200,
    parameter int QUIET_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              sdata_o,
    output logic              sdata_oe_o,
    output logic              powered_o,
    output logic              valid_o
);

    localparam int FRAME_W = DATA_W + LEAD_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int PIN_CS  = 1;
    localparam int PIN_CK  = 0;

    logic [1:0]       pin_fall, pin_rise;
    logic             start, step, abort;
    logic [CNT_W-1:0] cnt;

    adc_pin_sync #(
        .N       (2),
        .STAGES  (SYNC_STG),
        .RST_VAL (2'b11)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({cs_n_i, sclk_i}),
        .fall_o (pin_fall),
        .rise_o (pin_rise)
    );

    adc_frame_shift #(
        .DATA_W    (DATA_W),
        .LEAD_W    (LEAD_W),
        .QUIET_CYC (QUIET_CYC)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_fall_i   (pin_fall[PIN_CS]),
        .cs_rise_i   (pin_rise[PIN_CS]),
        .sclk_fall_i (pin_fall[PIN_CK]),
        .sample_i    (sample_i),
        .start_o     (start),
        .step_o      (step),
        .abort_o     (abort),
        .cnt_o       (cnt),
        .sdata_o     (sdata_o),
        .oe_o        (sdata_oe_o)
    );

    adc_pwr_ctrl #(
        .FRAME_W   (FRAME_W),
        .PD_LO     (PD_LO),
        .PD_HI     (PD_HI),
        .PWRUP_CYC (PWRUP_CYC)
    ) u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .step_i    (step),
        .abort_i   (abort),
        .cnt_i     (cnt),
        .powered_o (powered_o),
        .valid_o   (valid_o)
    );

    a_r3_line_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !sdata_oe_o |-> !sdata_o);

    a_r10_valid_means_powered: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(powered_o));

endmodule

// File: tb/tb_adc_frame_ctrl.sv
`timescale 1ns/1ps
module tb_adc_frame_ctrl;

    localparam int PWRUP = 200;
    localparam int QUIET = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic [11:0] sample = '0;
    logic        sdata, oe, powered, valid;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    adc_frame_ctrl #(.PWRUP_CYC(PWRUP), .QUIET_CYC(QUIET)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk),
        .sample_i(sample), .sdata_o(sdata), .sdata_oe_o(oe),
        .powered_o(powered), .valid_o(valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic        h_cs[3];
    logic        h_ck[3];
    bit          m_open;
    int          m_cnt, m_quiet, m_tmr;
    logic [15:0] m_word;
    int          m_pw;          // 0 powered, 1 off, 2 waking
    bit          m_commit, m_dummy, m_valid;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin h_cs[i] = 1'b1; h_ck[i] = 1'b1; end
            m_open = 0; m_cnt = 0; m_quiet = 0; m_tmr = 0; m_word = '0;
            m_pw = 0; m_commit = 0; m_dummy = 0; m_valid = 0;
        end else begin
            bit csf, csr, ckf, opened, stepped, aborted, done;
            int old_pw;
            csf = h_cs[2] && !h_cs[1];
            csr = !h_cs[2] && h_cs[1];
            ckf = h_ck[2] && !h_ck[1];
            opened = 0; stepped = 0; aborted = 0; done = 0;
            old_pw = m_pw;
            if (csf && !m_open && m_quiet == 0) begin
                opened = 1; m_open = 1; m_cnt = 0; m_word = {4'h0, sample};
            end else if (m_open) begin
                if (ckf) begin
                    stepped = 1; m_cnt++; m_word = m_word << 1;
                    if (m_cnt == 16) begin m_open = 0; done = 1; end
                end
                if (csr && m_open) begin m_open = 0; aborted = 1; end
            end
            if (done) m_quiet = QUIET;
            else if (m_quiet > 0) m_quiet--;
            // power bookkeeping, judged on values before this edge
            begin
                bit was_commit, was_dummy;
                int was_tmr;
                was_commit = m_commit; was_dummy = m_dummy; was_tmr = m_tmr;
                if (old_pw == 2 && m_tmr < PWRUP) m_tmr++;
                if (old_pw == 2 && was_commit && was_tmr == PWRUP) m_pw = 0;
                if (opened) begin
                    if (old_pw == 1) begin
                        m_pw = 2; m_tmr = 0; m_commit = 0; m_dummy = 1; m_valid = 0;
                    end else begin
                        m_dummy = 0; m_valid = (old_pw == 0);
                    end
                end
                if (stepped && was_dummy && m_cnt == 10) m_commit = 1;
                if (aborted) begin
                    if (was_dummy) begin
                        if (m_cnt < 10) begin m_pw = 1; m_commit = 0; m_dummy = 0; end
                    end else if (m_cnt >= 2 && m_cnt < 10) m_pw = 1;
                end
            end
            h_cs[2] = h_cs[1]; h_cs[1] = h_cs[0]; h_cs[0] = cs_n;
            h_ck[2] = h_ck[1]; h_ck[1] = h_ck[0]; h_ck[0] = sclk;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2 oe vs model", {31'b0, oe}, {31'b0, m_open});
            chk("R3 sdata vs model", {31'b0, sdata}, {31'b0, m_open & m_word[15]});
            chk("R6 powered vs model", {31'b0, powered}, {31'b0, m_pw == 0});
            chk("R10 valid vs model", {31'b0, valid}, {31'b0, m_valid});
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_frame(input logic [11:0] s, input int nfalls, input bit rise_on_last,
                             output logic [15:0] w);
        w = '0;
        sample = s;
        cs_n = 1'b0;
        wait_cyc(6);
        w[15] = sdata;
        for (int k = 1; k <= nfalls; k++) begin
            sclk = 1'b0;
            if (rise_on_last && k == nfalls) cs_n = 1'b1;
            wait_cyc(4);
            if (k < 16) w[15-k] = sdata;
            sclk = 1'b1;
            wait_cyc(4);
        end
        cs_n = 1'b1;
        wait_cyc(20);
    endtask

    initial begin
        logic [15:0] w;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        chk("R1 oe after reset", {31'b0, oe}, 0);
        chk("R1 sdata after reset", {31'b0, sdata}, 0);
        chk("R1 powered after reset", {31'b0, powered}, 1);
        chk("R1 valid after reset", {31'b0, valid}, 0);

        run_frame(12'hA5C, 16, 0, w);
        chk("R3 word A5C", {16'b0, w}, 32'h0A5C);
        chk("R4 oe after completion", {31'b0, oe}, 0);
        chk("R4 powered after completion", {31'b0, powered}, 1);
        chk("R10 valid when powered", {31'b0, valid}, 1);

        run_frame(12'h3F1, 16, 0, w);
        chk("R3 word 3F1", {16'b0, w}, 32'h03F1);

        run_frame(12'h555, 1, 0, w);
        chk("R5 glitch keeps power", {31'b0, powered}, 1);
        chk("R5 glitch closes frame", {31'b0, oe}, 0);

        run_frame(12'h555, 12, 0, w);
        chk("R7 late abort keeps power", {31'b0, powered}, 1);

        run_frame(12'h555, 10, 1, w);
        chk("R12 rise with 10th fall keeps power", {31'b0, powered}, 1);

        run_frame(12'h555, 5, 0, w);
        chk("R6 mid abort powers down", {31'b0, powered}, 0);

        run_frame(12'h111, 6, 0, w);
        wait_cyc(PWRUP + 50);
        chk("R8 short wake frame stays down", {31'b0, powered}, 0);

        run_frame(12'h123, 16, 0, w);
        chk("R9 dummy frame invalid", {31'b0, valid}, 0);
        chk("R9 not yet powered", {31'b0, powered}, 0);
        run_frame(12'h456, 16, 0, w);
        chk("R10 early frame invalid", {31'b0, valid}, 0);
        chk("R9 powered after delay", {31'b0, powered}, 1);
        run_frame(12'hFFF, 16, 0, w);
        chk("R10 valid after wake", {31'b0, valid}, 1);
        chk("R3 word FFF", {16'b0, w}, 32'h0FFF);

        run_frame(12'h555, 2, 1, w);
        chk("R12 rise with 2nd fall powers down", {31'b0, powered}, 0);
        run_frame(12'h222, 16, 0, w);
        wait_cyc(PWRUP + 50);
        chk("R9 wake restores power", {31'b0, powered}, 1);

        // quiet interval
        sample = 12'h0C3;
        cs_n = 1'b0;
        wait_cyc(6);
        for (int k = 1; k <= 16; k++) begin
            sclk = 1'b0; wait_cyc(4); sclk = 1'b1; wait_cyc(4);
        end
        cs_n = 1'b1;
        wait_cyc(1);
        cs_n = 1'b0;
        wait_cyc(6);
        chk("R11 fall in quiet time ignored", {31'b0, oe}, 0);
        cs_n = 1'b1;
        wait_cyc(30);
        run_frame(12'h0C3, 16, 0, w);
        chk("R11 frame after quiet time", {16'b0, w}, 32'h00C3);

        // select fall together with a serial clock fall
        sample = 12'h9A6;
        cs_n = 1'b0; sclk = 1'b0;
        wait_cyc(4); sclk = 1'b1; wait_cyc(4);
        for (int k = 1; k <= 16; k++) begin
            sclk = 1'b0; wait_cyc(4);
            if (k == 15) chk("R12 coincident fall not counted", {31'b0, oe}, 1);
            if (k == 16) chk("R12 sixteen further falls complete", {31'b0, oe}, 0);
            sclk = 1'b1; wait_cyc(4);
        end
        cs_n = 1'b1;
        wait_cyc(20);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule